// File: doc/BRIEF.md
# Circular Load/Store Queue Manager

This block keeps the per-thread load ring and store ring of an out-of-order core. Each ring is a circular buffer. Dispatch allocates an entry at the tail, and the slot index is returned to the issuer. Commit releases loads and marks stores as committed. A squash pulls the tail back over speculative entries. The load ring keeps a tag and a sequence number for each entry. The store ring also keeps an access size, the store data and three flags: committed, ready-to-write-back (committed and data present) and completed.

Store write-back is sequenced by a small state machine with two states. In `WB_IDLE` it offers the entry at the write-back pointer to the cache port when that entry is ready, not yet completed, and the port is not blocked. The offer is accepted in the same cycle, and the machine moves to `WB_WAIT` (transition *issue*). In `WB_WAIT` it waits for the cache's acknowledge. The acknowledge marks the entry completed and returns the machine to `WB_IDLE` (transition *ack*). A store slot is released only after its completion. Each ring keeps one slot free as a sentinel, so a ring of N slots reports full at N−1 entries.

Top module: `lsq_ring_mgr`

## Requirements
- R1: A ring of N slots holds at most N−1 entries. `ld_full` and `st_full` are high when their count is ≥ N−1.
- R2: An insert into a full ring is ignored: the count does not change and the insert index does not move.
- R3: `any_full` is `ld_full | st_full`. `free_cnt` is min(LD_SLOTS−1−`ld_cnt`, ST_SLOTS−1−`st_cnt`).
- R4: A commit with sequence C retires, in one cycle, every load whose sequence is below C. A load with sequence equal to C stays.
- R5: The same commit marks every uncommitted store below C as committed and adds their number to `st_pending`. Commit never releases a store slot.
- R6: `wb_vld` is high only in `WB_IDLE`, only while `cache_blocked` is low, and only when the entry at the write-back pointer is ready and not completed. `wb_idx`, `wb_size` and `wb_data` then describe that entry.
- R7: Only one write-back is outstanding at a time. `wb_ack` marks it completed and decrements `st_pending`, and the slot is released on the following cycle.
- R8: A store-data write records size and data into the addressed valid entry. A committed store whose data has not yet been written is not offered for write-back until the data arrives.
- R9: A squash with sequence S removes, in one cycle, every load and every uncommitted store whose sequence is above S. Inserts in the same cycle are ignored.
- R10: `ld_head_seq` and `st_head_seq` show the oldest entry's sequence, or 0 when the ring is empty.
- R11: Slot indices advance by one per accepted insert and wrap from N−1 to 0. A squash moves the insert index back.
- R12: After reset both rings are empty, all counts are 0 and no write-back is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ld_ins_vld | input | 1 | Allocate a load |
| ld_ins_tag | input | TAG_W | Load instruction tag |
| ld_ins_seq | input | SEQ_W | Load sequence number |
| ld_ins_idx | output | LD_IDX_W | Slot the next load goes to |
| st_ins_vld | input | 1 | Allocate a store |
| st_ins_tag | input | TAG_W | Store instruction tag |
| st_ins_seq | input | SEQ_W | Store sequence number |
| st_ins_idx | output | ST_IDX_W | Slot the next store goes to |
| st_wr_vld | input | 1 | Store-data write |
| st_wr_idx | input | ST_IDX_W | Store slot written |
| st_wr_size | input | SIZE_W | Access size in bytes |
| st_wr_data | input | DATA_W | Store data |
| commit_vld | input | 1 | Commit request |
| commit_seq | input | SEQ_W | Entries below this commit |
| squash_vld | input | 1 | Squash request |
| squash_seq | input | SEQ_W | Entries above this are removed |
| cache_blocked | input | 1 | Cache port cannot accept |
| wb_ack | input | 1 | Outstanding write-back finished |
| wb_vld | output | 1 | Write-back offered and accepted this cycle |
| wb_idx | output | ST_IDX_W | Slot being written back |
| wb_tag | output | TAG_W | Tag of that store |
| wb_size | output | SIZE_W | Size of that store |
| wb_data | output | DATA_W | Data of that store |
| ld_cnt | output | LD_CNT_W | Loads held |
| st_cnt | output | ST_CNT_W | Stores held |
| st_pending | output | ST_CNT_W | Committed stores not yet completed |
| ld_full | output | 1 | Load ring full |
| st_full | output | 1 | Store ring full |
| any_full | output | 1 | Either ring full |
| free_cnt | output | FREE_W | Smaller of the two free counts |
| ld_head_seq | output | SEQ_W | Oldest load sequence, 0 if empty |
| ld_head_tag | output | TAG_W | Oldest load tag, 0 if empty |
| st_head_seq | output | SEQ_W | Oldest store sequence, 0 if empty |

## Verification
The assertions assume that sequence numbers grow with program order and never wrap. They also assume that `wb_ack` arrives only while a write-back is outstanding, and that commit and squash do not overlap in the same cycle. The directed stimulus uses ascending small sequence numbers, raises `wb_ack` only after it has seen `wb_vld`, and keeps commit and squash in separate cycles. Under these conditions the count bounds, the full-hold rule, the blocked-port rule and the single-outstanding rule are checked on every cycle.

// File: rtl/lsq_ring_pkg.sv
package lsq_ring_pkg;

    typedef enum logic [0:0] {
        WB_IDLE = 1'b0,
        WB_WAIT = 1'b1
    } wb_state_e;

    // forward step on a ring of 'slots' entries, explicit wrap
    function automatic int ring_fwd(input int p, input int n, input int slots);
        int s;
        s = p + n;
        if (s >= slots) s = s - slots;
        return s;
    endfunction

    // backward step on a ring of 'slots' entries, explicit wrap
    function automatic int ring_back(input int p, input int n, input int slots);
        int s;
        s = p - n;
        if (s < 0) s = s + slots;
        return s;
    endfunction

endpackage

// File: rtl/lsq_load_ring.sv
module lsq_load_ring
    import lsq_ring_pkg::*;
#(
    parameter int SLOTS = 8,
    parameter int SEQ_W = 16,
    parameter int TAG_W = 6,
    localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int CNT_W = $clog2(SLOTS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ins_vld,
    input  logic [TAG_W-1:0] ins_tag,
    input  logic [SEQ_W-1:0] ins_seq,
    input  logic             commit_vld,
    input  logic [SEQ_W-1:0] commit_seq,
    input  logic             squash_vld,
    input  logic [SEQ_W-1:0] squash_seq,
    output logic [IDX_W-1:0] ins_idx,
    output logic [CNT_W-1:0] cnt,
    output logic             full,
    output logic [SEQ_W-1:0] head_seq,
    output logic [TAG_W-1:0] head_tag
);

    logic [SLOTS-1:0] vld_q;
    logic [SEQ_W-1:0] seq_q [SLOTS];
    logic [TAG_W-1:0] tag_q [SLOTS];
    logic [IDX_W-1:0] head_q, tail_q;
    logic [CNT_W-1:0] cnt_q;

    logic [SLOTS-1:0] retire_m, kill_m;
    logic [CNT_W-1:0] n_ret, n_kill;
    logic             accept;

    always_comb begin
        n_ret  = '0;
        n_kill = '0;
        for (int i = 0; i < SLOTS; i++) begin
            retire_m[i] = commit_vld && vld_q[i] && (seq_q[i] < commit_seq);
            kill_m[i]   = squash_vld && vld_q[i] && (seq_q[i] > squash_seq);
            n_ret  = n_ret  + CNT_W'(retire_m[i]);
            n_kill = n_kill + CNT_W'(kill_m[i]);
        end
    end

    assign full   = (cnt_q >= CNT_W'(SLOTS - 1));
    assign accept = ins_vld && !full && !squash_vld;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q  <= '0;
            head_q <= '0;
            tail_q <= '0;
            cnt_q  <= '0;
            for (int i = 0; i < SLOTS; i++) begin
                seq_q[i] <= '0;
                tag_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < SLOTS; i++) begin
                if (retire_m[i] || kill_m[i]) vld_q[i] <= 1'b0;
            end
            if (accept) begin
                vld_q[tail_q] <= 1'b1;
                seq_q[tail_q] <= ins_seq;
                tag_q[tail_q] <= ins_tag;
                tail_q <= IDX_W'(ring_fwd(int'(tail_q), 1, SLOTS));
            end else begin
                tail_q <= IDX_W'(ring_back(int'(tail_q), int'(n_kill), SLOTS));
            end
            head_q <= IDX_W'(ring_fwd(int'(head_q), int'(n_ret), SLOTS));
            cnt_q  <= cnt_q + CNT_W'(accept) - n_ret - n_kill;
        end
    end

    assign ins_idx  = tail_q;
    assign cnt      = cnt_q;
    assign head_seq = vld_q[head_q] ? seq_q[head_q] : '0;
    assign head_tag = vld_q[head_q] ? tag_q[head_q] : '0;

    // R1: occupancy never exceeds the usable capacity
    p_ld_cap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(SLOTS - 1));

    // R2: an insert into a full ring adds nothing
    p_ld_full_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (full && ins_vld && !commit_vld && !squash_vld) |=> (cnt_q == $past(cnt_q)));

    // R4: after a commit no remaining load is older than the commit point
    p_ld_retire_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_vld && !squash_vld) |=> (head_seq == '0 || head_seq >= $past(commit_seq)));

endmodule

// File: rtl/lsq_store_ring.sv
module lsq_store_ring
    import lsq_ring_pkg::*;
#(
    parameter int SLOTS  = 8,
    parameter int SEQ_W  = 16,
    parameter int TAG_W  = 6,
    parameter int DATA_W = 32,
    parameter int SIZE_W = 4,
    localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int CNT_W = $clog2(SLOTS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ins_vld,
    input  logic [TAG_W-1:0]  ins_tag,
    input  logic [SEQ_W-1:0]  ins_seq,
    input  logic              wr_vld,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [SIZE_W-1:0] wr_size,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              commit_vld,
    input  logic [SEQ_W-1:0]  commit_seq,
    input  logic              squash_vld,
    input  logic [SEQ_W-1:0]  squash_seq,
    input  logic              issue,
    input  logic              complete,
    output logic              cand_ok,
    output logic [IDX_W-1:0]  ins_idx,
    output logic [IDX_W-1:0]  wb_idx,
    output logic [TAG_W-1:0]  wb_tag,
    output logic [SIZE_W-1:0] wb_size,
    output logic [DATA_W-1:0] wb_data,
    output logic [CNT_W-1:0]  cnt,
    output logic [CNT_W-1:0]  pending,
    output logic              full,
    output logic [SEQ_W-1:0]  head_seq
);

    logic [SLOTS-1:0]  vld_q, cm_q, hd_q, cwb_q, done_q;
    logic [SEQ_W-1:0]  seq_q  [SLOTS];
    logic [TAG_W-1:0]  tag_q  [SLOTS];
    logic [SIZE_W-1:0] size_q [SLOTS];
    logic [DATA_W-1:0] data_q [SLOTS];
    logic [IDX_W-1:0]  head_q, tail_q, wbp_q, busy_q;
    logic [CNT_W-1:0]  cnt_q, pend_q;

    logic [SLOTS-1:0]  cm_hit, kill_m, wr_hit;
    logic [CNT_W-1:0]  n_cm, n_kill;
    logic              accept, free_head;

    always_comb begin
        n_cm   = '0;
        n_kill = '0;
        for (int i = 0; i < SLOTS; i++) begin
            cm_hit[i] = commit_vld && vld_q[i] && !cm_q[i] && (seq_q[i] < commit_seq);
            kill_m[i] = squash_vld && vld_q[i] && !cm_q[i] && (seq_q[i] > squash_seq);
            wr_hit[i] = wr_vld && vld_q[i] && (wr_idx == IDX_W'(i));
            n_cm   = n_cm   + CNT_W'(cm_hit[i]);
            n_kill = n_kill + CNT_W'(kill_m[i]);
        end
    end

    assign full      = (cnt_q >= CNT_W'(SLOTS - 1));
    assign accept    = ins_vld && !full && !squash_vld;
    assign free_head = vld_q[head_q] && done_q[head_q];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q  <= '0;
            cm_q   <= '0;
            hd_q   <= '0;
            cwb_q  <= '0;
            done_q <= '0;
            head_q <= '0;
            tail_q <= '0;
            wbp_q  <= '0;
            busy_q <= '0;
            cnt_q  <= '0;
            pend_q <= '0;
            for (int i = 0; i < SLOTS; i++) begin
                seq_q[i]  <= '0;
                tag_q[i]  <= '0;
                size_q[i] <= '0;
                data_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < SLOTS; i++) begin
                if (kill_m[i] || (free_head && head_q == IDX_W'(i))) begin
                    vld_q[i]  <= 1'b0;
                    cm_q[i]   <= 1'b0;
                    hd_q[i]   <= 1'b0;
                    cwb_q[i]  <= 1'b0;
                    done_q[i] <= 1'b0;
                end else if (accept && tail_q == IDX_W'(i)) begin
                    vld_q[i]  <= 1'b1;
                    seq_q[i]  <= ins_seq;
                    tag_q[i]  <= ins_tag;
                    size_q[i] <= '0;
                    data_q[i] <= '0;
                    cm_q[i]   <= 1'b0;
                    hd_q[i]   <= 1'b0;
                    cwb_q[i]  <= 1'b0;
                    done_q[i] <= 1'b0;
                end else if (vld_q[i]) begin
                    if (wr_hit[i]) begin
                        size_q[i] <= wr_size;
                        data_q[i] <= wr_data;
                        hd_q[i]   <= 1'b1;
                    end
                    cm_q[i]  <= cm_q[i] | cm_hit[i];
                    cwb_q[i] <= (cm_q[i] | cm_hit[i]) && (hd_q[i] | wr_hit[i]);
                    if (complete && busy_q == IDX_W'(i)) done_q[i] <= 1'b1;
                end
            end
            if (accept)
                tail_q <= IDX_W'(ring_fwd(int'(tail_q), 1, SLOTS));
            else
                tail_q <= IDX_W'(ring_back(int'(tail_q), int'(n_kill), SLOTS));
            if (free_head)
                head_q <= IDX_W'(ring_fwd(int'(head_q), 1, SLOTS));
            if (issue) begin
                wbp_q  <= IDX_W'(ring_fwd(int'(wbp_q), 1, SLOTS));
                busy_q <= wbp_q;
            end
            cnt_q  <= cnt_q + CNT_W'(accept) - CNT_W'(free_head) - n_kill;
            pend_q <= pend_q + n_cm - CNT_W'(complete);
        end
    end

    assign cand_ok  = vld_q[wbp_q] && cwb_q[wbp_q] && !done_q[wbp_q];
    assign ins_idx  = tail_q;
    assign wb_idx   = wbp_q;
    assign wb_tag   = tag_q[wbp_q];
    assign wb_size  = size_q[wbp_q];
    assign wb_data  = data_q[wbp_q];
    assign cnt      = cnt_q;
    assign pending  = pend_q;
    assign head_seq = vld_q[head_q] ? seq_q[head_q] : '0;

    // R1: occupancy never exceeds the usable capacity
    p_st_cap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(SLOTS - 1));

    // R2: an insert into a full ring adds nothing
    p_st_full_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (full && ins_vld && !squash_vld) |=> (cnt_q <= $past(cnt_q)));

    // R5: committed-but-incomplete stores are a subset of the held stores
    p_pend_le_cnt_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q <= cnt_q);

    // R8: only a committed store with data is ever written back
    p_issue_has_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> (cm_q[wbp_q] && hd_q[wbp_q]));

endmodule

// File: rtl/lsq_wb_fsm.sv
module lsq_wb_fsm
    import lsq_ring_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cand_ok,
    input  logic cache_blocked,
    input  logic wb_ack,
    output logic issue,
    output logic complete
);

    wb_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WB_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        issue    = 1'b0;
        complete = 1'b0;
        state_d  = state_q;
        unique case (state_q)
            WB_IDLE: begin
                issue = cand_ok && !cache_blocked;
                if (issue) state_d = WB_WAIT;
            end
            WB_WAIT: begin
                complete = wb_ack;
                if (wb_ack) state_d = WB_IDLE;
            end
            default: state_d = WB_IDLE;
        endcase
    end

    // R6: nothing is offered while the cache port is blocked
    p_no_issue_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cache_blocked |-> !issue);

    // R7: a write-back is never followed directly by another
    p_single_outst_r7: assert property (@(posedge clk) disable iff (!rst_n)
        issue |=> !issue);

endmodule

// File: rtl/lsq_ring_mgr.sv
module lsq_ring_mgr
    import lsq_ring_pkg::*;
#(
    parameter int LD_SLOTS = 8,
    parameter int ST_SLOTS = 8,
    parameter int SEQ_W    = 16,
    parameter int TAG_W    = 6,
    parameter int DATA_W   = 32,
    parameter int SIZE_W   = 4,
    localparam int LD_IDX_W = (LD_SLOTS > 1) ? $clog2(LD_SLOTS) : 1,
    localparam int ST_IDX_W = (ST_SLOTS > 1) ? $clog2(ST_SLOTS) : 1,
    localparam int LD_CNT_W = $clog2(LD_SLOTS + 1),
    localparam int ST_CNT_W = $clog2(ST_SLOTS + 1),
    localparam int FREE_W   = (LD_CNT_W > ST_CNT_W) ? LD_CNT_W : ST_CNT_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ld_ins_vld,
    input  logic [TAG_W-1:0]    ld_ins_tag,
    input  logic [SEQ_W-1:0]    ld_ins_seq,
    output logic [LD_IDX_W-1:0] ld_ins_idx,
    input  logic                st_ins_vld,
    input  logic [TAG_W-1:0]    st_ins_tag,
    input  logic [SEQ_W-1:0]    st_ins_seq,
    output logic [ST_IDX_W-1:0] st_ins_idx,
    input  logic                st_wr_vld,
    input  logic [ST_IDX_W-1:0] st_wr_idx,
    input  logic [SIZE_W-1:0]   st_wr_size,
    input  logic [DATA_W-1:0]   st_wr_data,
    input  logic                commit_vld,
    input  logic [SEQ_W-1:0]    commit_seq,
    input  logic                squash_vld,
    input  logic [SEQ_W-1:0]    squash_seq,
    input  logic                cache_blocked,
    input  logic                wb_ack,
    output logic                wb_vld,
    output logic [ST_IDX_W-1:0] wb_idx,
    output logic [TAG_W-1:0]    wb_tag,
    output logic [SIZE_W-1:0]   wb_size,
    output logic [DATA_W-1:0]   wb_data,
    output logic [LD_CNT_W-1:0] ld_cnt,
    output logic [ST_CNT_W-1:0] st_cnt,
    output logic [ST_CNT_W-1:0] st_pending,
    output logic                ld_full,
    output logic                st_full,
    output logic                any_full,
    output logic [FREE_W-1:0]   free_cnt,
    output logic [SEQ_W-1:0]    ld_head_seq,
    output logic [TAG_W-1:0]    ld_head_tag,
    output logic [SEQ_W-1:0]    st_head_seq
);

    logic cand_ok, issue, complete;

    lsq_load_ring #(.SLOTS(LD_SLOTS), .SEQ_W(SEQ_W), .TAG_W(TAG_W)) u_ld (
        .clk        (clk),
        .rst_n      (rst_n),
        .ins_vld    (ld_ins_vld),
        .ins_tag    (ld_ins_tag),
        .ins_seq    (ld_ins_seq),
        .commit_vld (commit_vld),
        .commit_seq (commit_seq),
        .squash_vld (squash_vld),
        .squash_seq (squash_seq),
        .ins_idx    (ld_ins_idx),
        .cnt        (ld_cnt),
        .full       (ld_full),
        .head_seq   (ld_head_seq),
        .head_tag   (ld_head_tag)
    );

    lsq_store_ring #(.SLOTS(ST_SLOTS), .SEQ_W(SEQ_W), .TAG_W(TAG_W),
                     .DATA_W(DATA_W), .SIZE_W(SIZE_W)) u_st (
        .clk        (clk),
        .rst_n      (rst_n),
        .ins_vld    (st_ins_vld),
        .ins_tag    (st_ins_tag),
        .ins_seq    (st_ins_seq),
        .wr_vld     (st_wr_vld),
        .wr_idx     (st_wr_idx),
        .wr_size    (st_wr_size),
        .wr_data    (st_wr_data),
        .commit_vld (commit_vld),
        .commit_seq (commit_seq),
        .squash_vld (squash_vld),
        .squash_seq (squash_seq),
        .issue      (issue),
        .complete   (complete),
        .cand_ok    (cand_ok),
        .ins_idx    (st_ins_idx),
        .wb_idx     (wb_idx),
        .wb_tag     (wb_tag),
        .wb_size    (wb_size),
        .wb_data    (wb_data),
        .cnt        (st_cnt),
        .pending    (st_pending),
        .full       (st_full),
        .head_seq   (st_head_seq)
    );

    lsq_wb_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .cand_ok       (cand_ok),
        .cache_blocked (cache_blocked),
        .wb_ack        (wb_ack),
        .issue         (issue),
        .complete      (complete)
    );

    assign wb_vld   = issue;
    assign any_full = ld_full | st_full;

    always_comb begin
        int ld_free, st_free;
        ld_free  = (LD_SLOTS - 1) - int'(ld_cnt);
        st_free  = (ST_SLOTS - 1) - int'(st_cnt);
        free_cnt = FREE_W'((ld_free < st_free) ? ld_free : st_free);
    end

    // R10: an empty load ring reports a zero head sequence
    p_head_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_cnt == '0) |-> (ld_head_seq == '0));

    // R3: full flag and free count agree
    p_full_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
        any_full |-> (free_cnt == '0));

endmodule

// File: tb/test_lsq_ring_mgr.sv
module test_lsq_ring_mgr;

    localparam int LDS = 4;
    localparam int STS = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_ins_vld = 0, st_ins_vld = 0, st_wr_vld = 0;
    logic        commit_vld = 0, squash_vld = 0, cache_blocked = 0, wb_ack = 0;
    logic [5:0]  ld_ins_tag = 0, st_ins_tag = 0;
    logic [15:0] ld_ins_seq = 0, st_ins_seq = 0, commit_seq = 0, squash_seq = 0;
    logic [2:0]  st_wr_idx = 0;
    logic [3:0]  st_wr_size = 0;
    logic [31:0] st_wr_data = 0;
    logic [1:0]  ld_ins_idx;
    logic [2:0]  st_ins_idx, wb_idx, ld_cnt, st_cnt, st_pending, free_cnt;
    logic        wb_vld, ld_full, st_full, any_full;
    logic [5:0]  wb_tag, ld_head_tag;
    logic [3:0]  wb_size;
    logic [31:0] wb_data;
    logic [15:0] ld_head_seq, st_head_seq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    lsq_ring_mgr #(.LD_SLOTS(LDS), .ST_SLOTS(STS)) i_lsq_ring_mgr (
        .clk(clk), .rst_n(rst_n),
        .ld_ins_vld(ld_ins_vld), .ld_ins_tag(ld_ins_tag), .ld_ins_seq(ld_ins_seq),
        .ld_ins_idx(ld_ins_idx),
        .st_ins_vld(st_ins_vld), .st_ins_tag(st_ins_tag), .st_ins_seq(st_ins_seq),
        .st_ins_idx(st_ins_idx),
        .st_wr_vld(st_wr_vld), .st_wr_idx(st_wr_idx), .st_wr_size(st_wr_size),
        .st_wr_data(st_wr_data),
        .commit_vld(commit_vld), .commit_seq(commit_seq),
        .squash_vld(squash_vld), .squash_seq(squash_seq),
        .cache_blocked(cache_blocked), .wb_ack(wb_ack),
        .wb_vld(wb_vld), .wb_idx(wb_idx), .wb_tag(wb_tag), .wb_size(wb_size),
        .wb_data(wb_data),
        .ld_cnt(ld_cnt), .st_cnt(st_cnt), .st_pending(st_pending),
        .ld_full(ld_full), .st_full(st_full), .any_full(any_full),
        .free_cnt(free_cnt), .ld_head_seq(ld_head_seq), .ld_head_tag(ld_head_tag),
        .st_head_seq(st_head_seq)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic put_ld(input int seq);
        ld_ins_vld = 1; ld_ins_seq = 16'(seq); ld_ins_tag = 6'(seq);
        tick();
        ld_ins_vld = 0;
    endtask

    task automatic put_st(input int seq);
        st_ins_vld = 1; st_ins_seq = 16'(seq); st_ins_tag = 6'(seq);
        tick();
        st_ins_vld = 0;
    endtask

    task automatic wr_st(input int idx, input int sz, input int dat);
        st_wr_vld = 1; st_wr_idx = 3'(idx); st_wr_size = 4'(sz); st_wr_data = 32'(dat);
        tick();
        st_wr_vld = 0;
    endtask

    task automatic do_commit(input int seq);
        commit_vld = 1; commit_seq = 16'(seq);
        tick();
        commit_vld = 0;
    endtask

    task automatic do_ack();
        wb_ack = 1;
        tick();
        wb_ack = 0;
    endtask

    task automatic t_reset();
        chk("R12", "ld_cnt", int'(ld_cnt), 0);
        chk("R12", "st_cnt", int'(st_cnt), 0);
        chk("R12", "wb_vld", int'(wb_vld), 0);
        chk("R10", "ld_head_seq empty", int'(ld_head_seq), 0);
        chk("R10", "st_head_seq empty", int'(st_head_seq), 0);
        chk("R3", "free_cnt reset", int'(free_cnt), 3);
    endtask

    task automatic t_load_fill();
        chk("R11", "ld idx 0", int'(ld_ins_idx), 0);
        put_ld(10);
        chk("R11", "ld idx 1", int'(ld_ins_idx), 1);
        put_ld(11);
        put_ld(12);
        chk("R1", "ld_full at 3", int'(ld_full), 1);
        chk("R3", "any_full", int'(any_full), 1);
        chk("R3", "free_cnt full", int'(free_cnt), 0);
        put_ld(13);
        chk("R2", "ld_cnt after ignored insert", int'(ld_cnt), 3);
        chk("R2", "ld idx unmoved", int'(ld_ins_idx), 3);
        chk("R10", "ld_head_seq", int'(ld_head_seq), 10);
    endtask

    task automatic t_load_commit();
        do_commit(12);
        chk("R4", "ld_cnt after commit 12", int'(ld_cnt), 1);
        chk("R4", "ld head keeps equal seq", int'(ld_head_seq), 12);
        chk("R3", "free_cnt", int'(free_cnt), 2);
        put_ld(13);
        chk("R11", "ld idx wrap", int'(ld_ins_idx), 0);
        put_ld(14);
        chk("R11", "ld idx after wrap", int'(ld_ins_idx), 1);
        do_commit(100);
        chk("R4", "ld_cnt all retired", int'(ld_cnt), 0);
        chk("R10", "ld head empty", int'(ld_head_seq), 0);
    endtask

    task automatic t_store_wb();
        chk("R11", "st idx 0", int'(st_ins_idx), 0);
        put_st(20); put_st(21); put_st(22);
        chk("R11", "st idx 3", int'(st_ins_idx), 3);
        wr_st(0, 4, 'hA0); wr_st(1, 2, 'hB1); wr_st(2, 1, 'hC2);
        chk("R3", "free_cnt min", int'(free_cnt), 2);
        cache_blocked = 1;
        do_commit(22);
        chk("R5", "pending", int'(st_pending), 2);
        chk("R5", "commit frees nothing", int'(st_cnt), 3);
        chk("R6", "blocked no offer", int'(wb_vld), 0);
        cache_blocked = 0;
        #1;
        chk("R6", "offer", int'(wb_vld), 1);
        chk("R6", "wb_idx", int'(wb_idx), 0);
        chk("R8", "wb_data", int'(wb_data), 'hA0);
        chk("R8", "wb_size", int'(wb_size), 4);
        tick();
        chk("R7", "no offer while waiting", int'(wb_vld), 0);
        tick();
        chk("R7", "still waiting", int'(wb_vld), 0);
        chk("R7", "not freed before ack", int'(st_cnt), 3);
        do_ack();
        chk("R7", "pending after ack", int'(st_pending), 1);
        chk("R7", "slot not yet freed", int'(st_cnt), 3);
        chk("R6", "next offer", int'(wb_vld), 1);
        chk("R6", "next wb_idx", int'(wb_idx), 1);
        chk("R8", "next data", int'(wb_data), 'hB1);
        chk("R8", "next size", int'(wb_size), 2);
        tick();
        chk("R7", "freed after ack", int'(st_cnt), 2);
        chk("R10", "st head", int'(st_head_seq), 21);
        do_ack();
        chk("R7", "pending zero", int'(st_pending), 0);
        chk("R6", "uncommitted not offered", int'(wb_vld), 0);
        tick();
        chk("R7", "second freed", int'(st_cnt), 1);
        chk("R10", "st head 22", int'(st_head_seq), 22);
    endtask

    task automatic t_squash();
        st_ins_vld = 1; st_ins_seq = 23; ld_ins_vld = 1; ld_ins_seq = 25;
        tick();
        st_ins_seq = 24; ld_ins_seq = 26;
        tick();
        st_ins_vld = 0; ld_ins_vld = 0;
        chk("R9", "st before squash", int'(st_cnt), 3);
        chk("R9", "ld before squash", int'(ld_cnt), 2);
        squash_vld = 1; squash_seq = 22;
        st_ins_vld = 1; st_ins_seq = 40; ld_ins_vld = 1; ld_ins_seq = 41;
        tick();
        squash_vld = 0; st_ins_vld = 0; ld_ins_vld = 0;
        chk("R9", "st after squash", int'(st_cnt), 1);
        chk("R9", "ld after squash", int'(ld_cnt), 0);
        chk("R11", "st idx back", int'(st_ins_idx), 3);
        chk("R11", "ld idx back", int'(ld_ins_idx), 1);
        chk("R9", "equal seq kept", int'(st_head_seq), 22);
    endtask

    task automatic t_late_data();
        put_st(27);
        do_commit(28);
        chk("R5", "pending two", int'(st_pending), 2);
        chk("R6", "offer idx2", int'(wb_idx), 2);
        chk("R8", "data idx2", int'(wb_data), 'hC2);
        tick();
        do_ack();
        chk("R8", "no data no offer", int'(wb_vld), 0);
        tick();
        chk("R7", "idx2 freed", int'(st_cnt), 1);
        chk("R10", "st head 27", int'(st_head_seq), 27);
        chk("R8", "still no offer", int'(wb_vld), 0);
        wr_st(3, 8, 'hD3);
        chk("R8", "offer after data", int'(wb_vld), 1);
        chk("R8", "late idx", int'(wb_idx), 3);
        chk("R8", "late data", int'(wb_data), 'hD3);
        chk("R8", "late size", int'(wb_size), 8);
        tick();
        do_ack();
        tick();
        chk("R7", "drained", int'(st_cnt), 0);
        chk("R10", "st head empty", int'(st_head_seq), 0);
        chk("R7", "pending drained", int'(st_pending), 0);
    endtask

    task automatic t_store_fill();
        chk("R11", "st idx 4", int'(st_ins_idx), 4);
        put_st(50);
        chk("R11", "st idx 5", int'(st_ins_idx), 5);
        put_st(51);
        chk("R11", "st idx wrap", int'(st_ins_idx), 0);
        put_st(52); put_st(53); put_st(54);
        chk("R1", "st_full", int'(st_full), 1);
        chk("R3", "any_full st", int'(any_full), 1);
        chk("R3", "free zero", int'(free_cnt), 0);
        put_st(55);
        chk("R2", "st ignored", int'(st_cnt), 5);
        chk("R2", "st idx unmoved", int'(st_ins_idx), 3);
        squash_vld = 1; squash_seq = 52;
        tick();
        squash_vld = 0;
        chk("R9", "partial squash", int'(st_cnt), 3);
        chk("R11", "idx after partial", int'(st_ins_idx), 1);
        chk("R1", "not full", int'(st_full), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_load_fill();
        t_load_commit();
        t_store_wb();
        t_squash();
        t_late_data();
        t_store_fill();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule